// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the digital side of a 12-bit serial converter so that a host controller can be tested in loopback. The host drives a conversion-start line (CONV) and a serial clock (SCK). The block answers on a serial data line (SDO) with a separate output-enable that marks when SDO would be driven rather than high impedance. The value to report arrives as a signed fixed-point word. The block rounds that word to the nearest code and saturates it to the code range. It captures the result when a conversion starts.

A rising CONV starts a conversion. The block captures the sample, releases SDO, and stays busy for a fixed number of system clocks. If CONV is still high when the conversion finishes, the block reports a sleep state. When CONV falls, the block drives SDO with the most significant bit of the code. Each later falling SCK edge moves SDO to the next lower bit, from bit 11 down to bit 0. After bit 0, SDO shows zero for any number of further clocks.

CONV and SCK are brought into the system clock domain through a synchroniser and an edge detector. Each of them must therefore stay at a level for several system clocks. An input change takes effect on the third rising system clock edge after it is sampled.

Top module: `serial_adc_emu`

## Requirements
- R1: A rising CONV edge while not busy latches the conditioned sample, drives sdo_oe low, and holds busy high for exactly CONV_CYCLES system clocks (default 20).
- R2: When the conversion time ends with CONV high, busy goes low and sleep goes high in the same cycle. When it ends with CONV low, sleep stays low.
- R3: A falling CONV edge sets sdo_oe high, drives sdo with bit 11 of the latched code, and clears sleep.
- R4: Each falling SCK edge while CONV is low and sdo_oe is high moves sdo to the next lower bit, so the code is sent most significant bit first. Between such edges, sdo does not change.
- R5: After bit 0 has been presented, every further falling SCK edge with CONV low presents 0, with no limit on the count.
- R6: Once rounded, an input above the full-scale code produces 4095, which is all ones.
- R7: An input whose rounded value is below zero produces code 0.
- R8: sample_in is signed and carries FRAC_W fraction bits (default 2, so the unit is a quarter LSB). The code is floor(v/4 + 1/2) for an input v in quarter-LSB units. Code transitions therefore fall at half-LSB points, and the code is straight binary.
- R9: A rising CONV edge that arrives while busy is ignored. The sample is not recaptured, the timer is not restarted, and sdo_oe and sdo do not change.
- R10: During and just after reset, sdo, sdo_oe, busy and sleep are all 0.
- R11: Falling SCK edges while CONV is high or while sdo_oe is low do not advance the shift position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv | input | 1 | Host conversion-start line, asynchronous to clk |
| sck | input | 1 | Host serial clock, asynchronous to clk, slow relative to clk |
| sample_in | input | IN_W (16) | Signed sample, FRAC_W fraction bits |
| sdo | output | 1 | Serial data, 0 while not enabled |
| sdo_oe | output | 1 | High when SDO is driven, low for high impedance |
| busy | output | 1 | Conversion in progress |
| sleep | output | 1 | Conversion finished with CONV still high |

## Verification
The assertions assume that CONV and SCK never toggle faster than the synchroniser can follow. Under that assumption, a CONV rise and a CONV fall can never be seen in the same cycle. They also assume that sample_in is steady around a CONV rise. The bench keeps every CONV and SCK level for at least four system clocks and sets sample_in well before raising CONV. One scenario deliberately drops CONV and raises it again inside the busy window, to exercise the ignored restart.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    localparam int CODE_W_DEF      = 12;
    localparam int IN_W_DEF        = 16;
    localparam int FRAC_W_DEF      = 2;
    localparam int CONV_CYCLES_DEF = 20;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_BUSY  = 2'd1,
        ST_SLEEP = 2'd2
    } adc_state_e;

endpackage

// File: rtl/adc_emu_sync_edge.sv
module adc_emu_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign lvl  = sync_q[STAGES-1];
    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_emu_clamp.sv
module adc_emu_clamp #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 2,
    parameter int CODE_W = 12
) (
    input  logic signed [IN_W-1:0]   value,
    output logic        [CODE_W-1:0] code
);

    localparam int SUM_W = IN_W + 1;
    localparam int HALF  = (FRAC_W > 0) ? (1 << (FRAC_W - 1)) : 0;
    localparam logic signed [SUM_W-1:0] HALF_V = SUM_W'(HALF);
    localparam logic signed [SUM_W-1:0] MAX_V  = SUM_W'((1 << CODE_W) - 1);

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] rounded;

    always_comb begin
        sum     = $signed({value[IN_W-1], value}) + HALF_V;
        rounded = sum >>> FRAC_W;
        if (rounded[SUM_W-1]) begin
            code = '0;
        end else if (rounded > MAX_V) begin
            code = '1;
        end else begin
            code = rounded[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/adc_emu_ctrl.sv
module adc_emu_ctrl
    import adc_emu_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_lvl,
    input  logic              conv_rise,
    input  logic              conv_fall,
    input  logic              sck_fall,
    input  logic [CODE_W-1:0] code_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy,
    output logic              sleep
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        adc_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] data;
        logic              oe;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_ACQ: begin
                if (conv_rise) begin
                    r_d.state = ST_BUSY;
                    r_d.cnt   = CNT_LOAD;
                    r_d.data  = code_in;
                    r_d.oe    = 1'b0;
                end else if (conv_fall) begin
                    r_d.oe = 1'b1;
                end
            end
            ST_BUSY: begin
                if (conv_fall) begin
                    r_d.oe = 1'b1;
                end
                if (r_q.cnt == '0) begin
                    r_d.state = conv_lvl ? ST_SLEEP : ST_ACQ;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SLEEP: begin
                if (conv_fall) begin
                    r_d.state = ST_ACQ;
                    r_d.oe    = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_ACQ;
            end
        endcase
        if (sck_fall && r_q.oe && !conv_lvl && !conv_rise) begin
            r_d.data = {r_q.data[CODE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_ACQ;
            r_q.cnt   <= '0;
            r_q.data  <= '0;
            r_q.oe    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo    = r_q.oe & r_q.data[CODE_W-1];
    assign sdo_oe = r_q.oe;
    assign busy   = (r_q.state == ST_BUSY);
    assign sleep  = (r_q.state == ST_SLEEP);

endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu
    import adc_emu_pkg::*;
#(
    parameter int CODE_W      = CODE_W_DEF,
    parameter int IN_W        = IN_W_DEF,
    parameter int FRAC_W      = FRAC_W_DEF,
    parameter int CONV_CYCLES = CONV_CYCLES_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv,
    input  logic                   sck,
    input  logic signed [IN_W-1:0] sample_in,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic                   busy,
    output logic                   sleep
);

    logic              conv_lvl, conv_rise, conv_fall;
    logic              sck_lvl, sck_rise, sck_fall;
    logic [CODE_W-1:0] code;

    adc_emu_sync_edge #(.STAGES(SYNC_STAGES)) conv_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (conv),
        .lvl  (conv_lvl),
        .rise (conv_rise),
        .fall (conv_fall)
    );

    adc_emu_sync_edge #(.STAGES(SYNC_STAGES)) sck_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sck),
        .lvl  (sck_lvl),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    adc_emu_clamp #(
        .IN_W  (IN_W),
        .FRAC_W(FRAC_W),
        .CODE_W(CODE_W)
    ) clamp_i (
        .value(sample_in),
        .code (code)
    );

    adc_emu_ctrl #(
        .CODE_W     (CODE_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_lvl (conv_lvl),
        .conv_rise(conv_rise),
        .conv_fall(conv_fall),
        .sck_fall (sck_fall),
        .code_in  (code),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .busy     (busy),
        .sleep    (sleep)
    );

    logic unused_sck;
    assign unused_sck = sck_lvl ^ sck_rise;

endmodule

// File: rtl/serial_adc_emu_chk.sv
module serial_adc_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_lvl,
    input logic conv_rise,
    input logic conv_fall,
    input logic sck_fall,
    input logic sdo,
    input logic sdo_oe,
    input logic busy,
    input logic sleep
);

    assert_hiz_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rise && !busy |=> busy && !sdo_oe);

    assert_sleep_after_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(conv_lvl) |-> sleep);

    assert_awake_after_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !$past(conv_lvl) |-> !sleep);

    assert_fall_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_fall |=> sdo_oe && !sleep);

    assert_hold_between_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe && $past(sdo_oe) && !$past(sck_fall) && !$past(conv_rise) |-> $stable(sdo));

    assert_ignore_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && conv_rise && !sck_fall |=> $stable(sdo_oe) && $stable(sdo));

endmodule

bind serial_adc_emu serial_adc_emu_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_lvl (conv_lvl),
    .conv_rise(conv_rise),
    .conv_fall(conv_fall),
    .sck_fall (sck_fall),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .busy     (busy),
    .sleep    (sleep)
);

// File: tb/serial_adc_emu_tb_top.sv
`timescale 1ns/1ps
module serial_adc_emu_tb_top;

    localparam int CONV_CYCLES = 20;
    localparam int IN_W        = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   conv = 1'b0;
    logic                   sck = 1'b0;
    logic signed [IN_W-1:0] sample_in = '0;
    logic                   sdo, sdo_oe, busy, sleep;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    serial_adc_emu #(.CONV_CYCLES(CONV_CYCLES)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv     (conv),
        .sck      (sck),
        .sample_in(sample_in),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .busy     (busy),
        .sleep    (sleep)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulse();
        sck = 1'b1;
        wait_cyc(4);
        sck = 1'b0;
        wait_cyc(4);
    endtask

    task automatic read_bits(input int n, output logic [31:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            w = {w[30:0], sdo};
            sck_pulse();
        end
    endtask

    task automatic convert(input int v);
        sample_in = IN_W'(v);
        wait_cyc(2);
        conv = 1'b1;
        wait_cyc(CONV_CYCLES + 8);
        conv = 1'b0;
        wait_cyc(5);
    endtask

    task automatic conv_and_check(input string tag, input int v, input int exp);
        logic [31:0] w;
        convert(v);
        read_bits(12, w);
        check(tag, int'(w[11:0]), exp);
    endtask

    task automatic t_reset();
        check("R10 sdo", int'(sdo), 0);
        check("R10 sdo_oe", int'(sdo_oe), 0);
        check("R10 busy", int'(busy), 0);
        check("R10 sleep", int'(sleep), 0);
    endtask

    task automatic t_timing();
        sample_in = IN_W'(4 * 12'hA5C);
        wait_cyc(2);
        conv = 1'b1;
        wait_cyc(3);
        check("R1 busy at start", int'(busy), 1);
        check("R1 sdo_oe low", int'(sdo_oe), 0);
        wait_cyc(CONV_CYCLES - 1);
        check("R1 busy last cycle", int'(busy), 1);
        wait_cyc(1);
        check("R1 busy ended", int'(busy), 0);
        check("R2 sleep with conv high", int'(sleep), 1);
        conv = 1'b0;
        wait_cyc(3);
        check("R3 sleep cleared", int'(sleep), 0);
        check("R3 sdo_oe high", int'(sdo_oe), 1);
        check("R3 msb presented", int'(sdo), 1);
    endtask

    task automatic t_msb_first();
        logic [31:0] w;
        convert(4 * 12'hA5C);
        read_bits(12, w);
        check("R4 msb first word", int'(w[11:0]), 12'hA5C);
        convert(4 * 12'h3C1);
        read_bits(12, w);
        check("R4 second pattern", int'(w[11:0]), 12'h3C1);
    endtask

    task automatic t_zero_fill();
        logic [31:0] w;
        convert(4 * 12'hFFF);
        read_bits(16, w);
        check("R5 word with 16 clocks", int'(w[15:4]), 12'hFFF);
        check("R5 four trailing zeros", int'(w[3:0]), 0);
        read_bits(20, w);
        check("R5 twenty more zeros", int'(w[19:0]), 0);
        check("R5 sdo_oe stays high", int'(sdo_oe), 1);
    endtask

    task automatic t_clamp();
        conv_and_check("R6 above full scale", 4 * 4095 + 2, 4095);
        conv_and_check("R6 largest input", 32767, 4095);
        conv_and_check("R7 below zero", -3, 0);
        conv_and_check("R7 most negative", -32768, 0);
        conv_and_check("R8 quarter rounds down", 4 * 100 + 1, 100);
        conv_and_check("R8 half rounds up", 4 * 100 + 2, 101);
        conv_and_check("R8 small negative rounds to zero", -1, 0);
        conv_and_check("R8 top just under half", 4 * 4095 + 1, 4095);
    endtask

    task automatic t_ignore_busy_rise();
        logic [31:0] w;
        sample_in = IN_W'(4 * 12'h5A3);
        wait_cyc(2);
        conv = 1'b1;
        wait_cyc(6);
        conv = 1'b0;
        wait_cyc(6);
        sample_in = IN_W'(4 * 12'h0F0);
        conv = 1'b1;
        wait_cyc(5);
        check("R9 sdo_oe kept after ignored rise", int'(sdo_oe), 1);
        check("R9 still busy", int'(busy), 1);
        wait_cyc(6);
        check("R9 timer not restarted", int'(busy), 0);
        check("R2 sleep after ignored rise", int'(sleep), 1);
        conv = 1'b0;
        wait_cyc(5);
        read_bits(12, w);
        check("R9 first sample kept", int'(w[11:0]), 12'h5A3);
    endtask

    task automatic t_end_low();
        sample_in = IN_W'(4 * 12'h800);
        wait_cyc(2);
        conv = 1'b1;
        wait_cyc(5);
        conv = 1'b0;
        wait_cyc(CONV_CYCLES + 5);
        check("R2 no sleep with conv low", int'(sleep), 0);
        check("R2 busy cleared", int'(busy), 0);
        check("R3 msb after early fall", int'(sdo), 1);
    endtask

    task automatic t_sck_ignored();
        logic [31:0] w;
        sample_in = IN_W'(4 * 12'hC35);
        wait_cyc(2);
        conv = 1'b1;
        wait_cyc(CONV_CYCLES + 8);
        for (int i = 0; i < 3; i++) sck_pulse();
        conv = 1'b0;
        wait_cyc(5);
        read_bits(12, w);
        check("R11 sck with conv high ignored", int'(w[11:0]), 12'hC35);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_cyc(1);
        t_reset();
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_timing();
        t_msb_first();
        t_zero_fill();
        t_clamp();
        t_ignore_busy_rise();
        t_end_low();
        t_sck_ignored();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule